// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address by fetching one page table entry from memory. The virtual address is split into a virtual page number (upper bits) and a page offset (lower bits, 10 bits wide for 1 KB pages). The entry's memory address is the current table base plus the virtual page number. The fetched entry is then tested for presence and for permission against the kind of access requested. If the entry is present and the access is allowed, the physical page number is joined with the unchanged offset and returned. If not, a fault code is returned.

A request is taken only while the walker is idle. Each walk passes through four states in a fixed order: idle, entry read, check, respond. The response is a single-cycle pulse carrying the physical address and a fault code: none, page fault or protection fault.

Loading a new table base switches the walker to another process's table. Such a load is honoured only while idle. A load issued during a walk is dropped, and the walk finishes with the base it started with.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_rd_en` are 0, and the table base is 0, so the first walk reads address equal to its virtual page number.
- R2: `req_ready` is 1 only when idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1, and `req_ready` stays 0 until the walk's response cycle has ended.
- R3: In the cycle after a request is taken, `mem_rd_en` is 1 for exactly one cycle, with `mem_rd_addr` = (base + virtual page number) modulo 2^MEM_AW.
- R4: `rsp_valid` is a single-cycle pulse two cycles after the `mem_rd_en` cycle. The memory returns `mem_rd_data` in the cycle after `mem_rd_en`.
- R5: Entry layout: bit 0 is the valid bit, bits 2:1 hold the rights code, and the bits above hold the physical page number. An entry whose valid bit is 0 gives fault code 01 (page fault), whatever its rights code and access kind.
- R6: On success, the fault code is 00 and `rsp_paddr` = {physical page number, the request's low 10 offset bits unchanged}.
- R7: Rights code 00 (read-only) allows loads only. Code 01 (read/write) allows loads and stores. Code 10 (execute) allows loads and fetches. Code 11 is reserved and allows nothing. A refused access on a valid entry gives fault code 10 (protection fault).
- R8: Access codes are 00 load, 01 store and 10 fetch. Access code 11 on a valid entry always gives fault code 10.
- R9: Any faulting response drives `rsp_paddr` to 0.
- R10: A base load while idle takes effect at that edge. If it coincides with the accepted request, the new base already forms that walk's entry address.
- R11: A base load while a walk is in flight is ignored. The walk and every later walk use the old base until a load is made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_access | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | PA_W | Physical address, 0 on fault |
| rsp_fault | output | 2 | 00 none, 01 page fault, 10 protection fault |
| mem_rd_en | output | 1 | Entry read strobe |
| mem_rd_addr | output | MEM_AW | Entry address |
| mem_rd_data | input | PPN_W+3 | Entry read data, one cycle after the strobe |
| base_wr_en | input | 1 | Load the table base |
| base_wr_data | input | MEM_AW | New table base |

## Verification
The assertions check, on every cycle, the timing of a walk:
- the single-cycle read strobe after an accepted request;
- the response pulse two cycles after that strobe;
- `req_ready` staying low during a response;
- the table base holding steady while busy;
- the zeroed address on faults;
- the offset carried unchanged on success.

Only the bench's scenarios show that the right entry is fetched and decoded, and that the fault code matches the rights table. The bench sweeps every virtual page number under every access code and three table bases, one of which makes the entry address wrap. It also shows how base loads interact with walks, both coinciding with a request and arriving mid-walk.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        RGT_RO   = 2'b00,
        RGT_RW   = 2'b01,
        RGT_EX   = 2'b10,
        RGT_RSVD = 2'b11
    } rights_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_PAGE = 2'b01,
        FLT_PROT = 2'b10
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_READ  = 2'b01,
        ST_CHECK = 2'b10,
        ST_RESP  = 2'b11
    } walk_st_e;

    // Entry field positions, decoded by the permission unit.
    localparam int PTE_VALID_BIT  = 0;
    localparam int PTE_RIGHTS_LSB = 1;
    localparam int PTE_PPN_LSB    = 3;

endpackage

// File: rtl/pgwalk_base_reg.sv
module pgwalk_base_reg #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    input  logic          busy,
    output logic [AW-1:0] base_o
);

    logic [AW-1:0] base_d, base_q;

    always_comb begin
        base_d = base_q;
        if (wr_en && !busy) begin
            base_d = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else begin
            base_q <= base_d;
        end
    end

    assign base_o = base_q;

    // R11
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(base_q));

endmodule

// File: rtl/pgwalk_perm.sv
module pgwalk_perm
    import pgwalk_pkg::*;
(
    input  logic       pte_valid,
    input  logic [1:0] rights,
    input  logic [1:0] access,
    output logic [1:0] fault_o
);

    logic allowed;

    always_comb begin
        allowed = 1'b0;
        unique case (rights)
            RGT_RO:  allowed = (access == ACC_LOAD);
            RGT_RW:  allowed = (access == ACC_LOAD) || (access == ACC_STORE);
            RGT_EX:  allowed = (access == ACC_LOAD) || (access == ACC_FETCH);
            default: allowed = 1'b0;
        endcase
    end

    always_comb begin
        if (!pte_valid) begin
            fault_o = FLT_PAGE;
        end else if (allowed) begin
            fault_o = FLT_NONE;
        end else begin
            fault_o = FLT_PROT;
        end
    end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int VA_W   = 16,
    parameter int PA_W   = 14,
    parameter int OFF_W  = 10,
    parameter int MEM_AW = 12,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int PPN_W = PA_W - OFF_W,
    localparam int PTE_W = PPN_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_access,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_fault,
    output logic              mem_rd_en,
    output logic [MEM_AW-1:0] mem_rd_addr,
    input  logic [PTE_W-1:0]  mem_rd_data,
    input  logic              base_wr_en,
    input  logic [MEM_AW-1:0] base_wr_data
);

    typedef struct packed {
        walk_st_e        st;
        logic [VA_W-1:0] va;
        logic [1:0]      acc;
        logic            rsp_v;
        logic [PA_W-1:0] paddr;
        logic [1:0]      fault;
    } walk_s;

    walk_s walk_d, walk_q;

    logic [MEM_AW-1:0] base;
    logic [1:0]        chk_fault;
    logic [PPN_W-1:0]  pte_ppn;
    logic              busy;

    assign busy    = (walk_q.st != ST_IDLE);
    assign pte_ppn = mem_rd_data[PTE_PPN_LSB +: PPN_W];

    pgwalk_base_reg #(.AW(MEM_AW)) base_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (base_wr_en),
        .wr_data (base_wr_data),
        .busy    (busy),
        .base_o  (base)
    );

    pgwalk_perm perm_i (
        .pte_valid (mem_rd_data[PTE_VALID_BIT]),
        .rights    (mem_rd_data[PTE_RIGHTS_LSB +: 2]),
        .access    (walk_q.acc),
        .fault_o   (chk_fault)
    );

    always_comb begin
        walk_d       = walk_q;
        walk_d.rsp_v = 1'b0;
        unique case (walk_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    walk_d.va  = req_vaddr;
                    walk_d.acc = req_access;
                    walk_d.st  = ST_READ;
                end
            end
            ST_READ: begin
                walk_d.st = ST_CHECK;
            end
            ST_CHECK: begin
                walk_d.fault = chk_fault;
                walk_d.paddr = (chk_fault == FLT_NONE)
                             ? {pte_ppn, walk_q.va[OFF_W-1:0]} : '0;
                walk_d.rsp_v = 1'b1;
                walk_d.st    = ST_RESP;
            end
            default: begin
                walk_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '{st: ST_IDLE, va: '0, acc: '0, rsp_v: 1'b0,
                        paddr: '0, fault: '0};
        end else begin
            walk_q <= walk_d;
        end
    end

    assign req_ready   = !busy;
    assign mem_rd_en   = (walk_q.st == ST_READ);
    assign mem_rd_addr = base + MEM_AW'(walk_q.va[VA_W-1:OFF_W]);
    assign rsp_valid   = walk_q.rsp_v;
    assign rsp_paddr   = walk_q.paddr;
    assign rsp_fault   = walk_q.fault;

    // R2
    ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R3
    rd_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> mem_rd_en);

    // R3
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R4
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> ##1 rsp_valid);

    // R4
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_NONE)
            |-> rsp_paddr[OFF_W-1:0] == walk_q.va[OFF_W-1:0]);

    // R9
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_NONE) |-> rsp_paddr == '0);

endmodule

// File: tb/pgwalk_top_tb_top.sv
module pgwalk_top_tb_top;

    localparam int VA_W   = 16;
    localparam int PA_W   = 14;
    localparam int OFF_W  = 10;
    localparam int MEM_AW = 12;
    localparam int PTE_W  = PA_W - OFF_W + 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic              req_ready;
    logic [VA_W-1:0]   req_vaddr;
    logic [1:0]        req_access;
    logic              rsp_valid;
    logic [PA_W-1:0]   rsp_paddr;
    logic [1:0]        rsp_fault;
    logic              mem_rd_en;
    logic [MEM_AW-1:0] mem_rd_addr;
    logic [PTE_W-1:0]  mem_rd_data;
    logic              base_wr_en;
    logic [MEM_AW-1:0] base_wr_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pgwalk_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_vaddr    (req_vaddr),
        .req_access   (req_access),
        .rsp_valid    (rsp_valid),
        .rsp_paddr    (rsp_paddr),
        .rsp_fault    (rsp_fault),
        .mem_rd_en    (mem_rd_en),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_data  (mem_rd_data),
        .base_wr_en   (base_wr_en),
        .base_wr_data (base_wr_data)
    );

    // Table contents, computed from the address.
    function automatic logic [PTE_W-1:0] pte_of(input int addr);
        logic       v;
        logic [1:0] r;
        logic [3:0] p;
        v = (addr % 5) != 0;
        r = 2'((addr / 3) % 4);
        p = 4'((addr * 7 + 3) % 16);
        return {p, r, v};
    endfunction

    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= pte_of(int'(mem_rd_addr));
    end

    function automatic logic [1:0] exp_fault(input logic [PTE_W-1:0] pte,
                                             input logic [1:0] acc);
        logic ok;
        if (!pte[0]) return 2'b01;               // R5
        case (pte[2:1])                          // R7, R8
            2'b00:   ok = (acc == 2'b00);
            2'b01:   ok = (acc == 2'b00) || (acc == 2'b01);
            2'b10:   ok = (acc == 2'b00) || (acc == 2'b10);
            default: ok = 1'b0;
        endcase
        return ok ? 2'b00 : 2'b10;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Full walk; optional base load coinciding with the request (R10)
    // or arriving during the read cycle (R11).
    task automatic walk(input logic [VA_W-1:0] va, input logic [1:0] acc,
                        input logic [MEM_AW-1:0] base_exp,
                        input bit wr_same, input bit wr_mid,
                        input logic [MEM_AW-1:0] wr_val);
        logic [MEM_AW-1:0] eaddr;
        logic [PTE_W-1:0]  pte;
        logic [1:0]        ef;
        logic [PA_W-1:0]   ep;
        eaddr = base_exp + MEM_AW'(va[VA_W-1:OFF_W]);
        pte   = pte_of(int'(eaddr));
        ef    = exp_fault(pte, acc);
        ep    = (ef == 2'b00) ? {pte[PTE_W-1:3], va[OFF_W-1:0]} : '0;
        @(negedge clk);
        chk("R2 ready idle", 32'(req_ready), 1);
        req_valid  = 1'b1;
        req_vaddr  = va;
        req_access = acc;
        if (wr_same) begin
            base_wr_en   = 1'b1;
            base_wr_data = wr_val;
        end
        @(negedge clk);
        req_valid  = 1'b0;
        base_wr_en = 1'b0;
        chk("R2 ready busy", 32'(req_ready), 0);
        chk("R3 rd_en", 32'(mem_rd_en), 1);
        chk(wr_same ? "R10 rd_addr" : (wr_mid ? "R11 rd_addr" : "R3 rd_addr"),
            32'(mem_rd_addr), 32'(eaddr));
        if (wr_mid) begin
            base_wr_en   = 1'b1;
            base_wr_data = wr_val;
        end
        @(negedge clk);
        base_wr_en = 1'b0;
        chk("R3 rd_en one cycle", 32'(mem_rd_en), 0);
        chk("R4 no early rsp", 32'(rsp_valid), 0);
        @(negedge clk);
        chk("R4 rsp_valid", 32'(rsp_valid), 1);
        chk("R5 R7 R8 fault", 32'(rsp_fault), 32'(ef));
        chk(ef == 2'b00 ? "R6 paddr" : "R9 paddr", 32'(rsp_paddr), 32'(ep));
        @(negedge clk);
        chk("R4 pulse end", 32'(rsp_valid), 0);
    endtask

    task automatic load_base(input logic [MEM_AW-1:0] v);
        @(negedge clk);
        base_wr_en   = 1'b1;
        base_wr_data = v;
        @(negedge clk);
        base_wr_en   = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R4 watchdog expired actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [MEM_AW-1:0] bases [3];
        bases[0] = 12'h000;
        bases[1] = 12'h3F0;
        bases[2] = 12'hFE0;      // wraps past the top of memory
        rst_n        = 1'b0;
        req_valid    = 1'b0;
        req_vaddr    = '0;
        req_access   = '0;
        base_wr_en   = 1'b0;
        base_wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", 32'(req_ready), 1);
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 rd_en", 32'(mem_rd_en), 0);
        // R1: no base load yet, so the base is 0.
        walk(16'h1C05, 2'b00, 12'h000, 1'b0, 1'b0, '0);

        for (int b = 0; b < 3; b++) begin
            if (b != 0) load_base(bases[b]);
            for (int vpn = 0; vpn < 64; vpn++) begin
                for (int acc = 0; acc < 4; acc++) begin
                    logic [VA_W-1:0] va;
                    va = {6'(vpn), 10'((vpn * 37 + acc * 101 + b * 13) % 1024)};
                    walk(va, 2'(acc), bases[b], 1'b0, 1'b0, '0);
                end
            end
        end

        // R10: load coinciding with the request uses the new base.
        walk(16'h0A33, 2'b01, 12'h120, 1'b1, 1'b0, 12'h120);
        walk(16'h0C00, 2'b10, 12'h120, 1'b0, 1'b0, '0);
        // R11: mid-walk load is dropped, and the old base persists.
        walk(16'h1111, 2'b00, 12'h120, 1'b0, 1'b1, 12'h777);
        walk(16'h2222, 2'b01, 12'h120, 1'b0, 1'b0, '0);
        // R10: an idle load still works afterwards.
        load_base(12'h555);
        walk(16'h3FFF, 2'b10, 12'h555, 1'b0, 1'b0, '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule